// File: doc/BRIEF.md
# Brightness, Contrast and Saturation Adjuster

This block adjusts a stream of 4:2:2 YUV video samples. Each sample enters with a tag that marks it as luma or as chroma (Cb and Cr share the chroma path). Three plain 8-bit setting inputs control the result. The brightness level is added to the luma result. The contrast gain scales luma around mid-level, with 71 as unity gain. The saturation gain scales chroma around the colourless level 128, with 64 as unity gain. Every result is clamped to the range 1..254, so the codes 0 and 255 stay free for timing references.

The datapath has three register stages. Samples move on a valid/ready handshake at both ends. A transfer takes place on a rising edge where valid and ready are both high. The upstream ready output is high when the output register is empty or the downstream side is ready. The ready output therefore depends combinationally on `m_ready`. The whole pipeline advances or holds as one unit. When the output is stalled, the output holds its data and nothing new is accepted.

The three settings are copied into working registers only on a clock edge where the pipeline is empty and no sample is being accepted. A change to the settings while samples are in flight therefore never splits one burst between two settings. To apply new settings, hold the stream idle for at least one cycle after the pipeline drains.

Top module: `bcs_adjust`

## Requirements
- R1: A luma sample (s_luma=1) with value Y produces clamp(trunc(G*(Y-128)/71) + B), where G is the contrast gain and B the brightness level, both unsigned 0..255. The division is exact for every G and Y.
- R2: A chroma sample (s_luma=0) with value C produces clamp(trunc(S*(C-128)/64) + 128), where S is the saturation gain.
- R3: The quotient truncates toward zero when the product is negative. For example, Y=127 with gain 1 gives B, not B-1.
- R4: clamp() limits every output to 1..254. Codes 0 and 255 never appear on m_sample while m_valid is high.
- R5: With brightness 128, contrast 71 and saturation 64, every sample from 1 to 254 passes through unchanged.
- R6: With m_ready held high, a sample accepted on a rising edge is shown on m_valid/m_sample after the third rising edge, counting the accepting edge as the first.
- R7: While m_valid=1 and m_ready=0, s_ready is 0 and m_valid, m_sample and m_luma hold their values. No sample is lost, duplicated or reordered.
- R8: The settings take effect only on an edge where no sample is in the pipeline and none is being accepted. Changes made while samples are in flight do not affect those samples.
- R9: m_luma carries the s_luma tag of the same sample.
- R10: While rst_n is low, m_valid is 0 and s_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bright | input | 8 | Brightness level added to luma |
| cfg_contrast | input | 8 | Luma gain, 71 = unity |
| cfg_sat | input | 8 | Chroma gain, 64 = unity |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_luma | input | 1 | 1 = luma sample, 0 = chroma sample |
| s_sample | input | 8 | Input sample value |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream can take the output |
| m_luma | output | 1 | Tag of the output sample |
| m_sample | output | 8 | Adjusted sample, 1..254 |

## Verification
A hand-computed vector table covers unity settings at black, white and both extremes, zero gains, and exact multiples of 71. Some vectors have negative products whose quotient is fractional; these separate truncation toward zero from flooring for both divisors. Two full sweeps then run every contrast gain against every luma value and every saturation gain against every chroma value, and compare against plain integer division. These sweeps show whether the reciprocal divider is exact over its whole input range. A burst under random output stalls with mixed tags checks ordering and holding. A settings change made while samples are in flight shows whether the new settings reach samples too early.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // ceil(2^shift / div): reciprocal used for exact constant division
  function automatic longint unsigned recip_const(input int div, input int shift);
    return ((64'd1 << shift) + 64'(div) - 64'd1) / 64'(div);
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/bcs_settings.sv
module bcs_settings #(
  parameter int DW         = 8,
  parameter int R_BRIGHT   = 128,
  parameter int R_CONTRAST = 71,
  parameter int R_SAT      = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] bright_i,
  input  logic [DW-1:0] contrast_i,
  input  logic [DW-1:0] sat_i,
  output logic [DW-1:0] bright_o,
  output logic [DW-1:0] contrast_o,
  output logic [DW-1:0] sat_o
);
  // R8: working copy only follows the ports when the pipe is empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bright_o   <= DW'(R_BRIGHT);
      contrast_o <= DW'(R_CONTRAST);
      sat_o      <= DW'(R_SAT);
    end else if (load_i) begin
      bright_o   <= bright_i;
      contrast_o <= contrast_i;
      sat_o      <= sat_i;
    end
  end
endmodule

// File: rtl/bcs_scale.sv
module bcs_scale #(
  parameter int MW      = 16,
  parameter int DIVISOR = 71
) (
  input  logic signed [MW:0] prod_i,
  output logic signed [MW:0] quo_o
);
  logic          neg;
  logic [MW-1:0] mag;
  logic [MW-1:0] qmag;

  // R3: divide the magnitude, then restore the sign -> truncation toward zero
  assign neg = prod_i[MW];
  assign mag = neg ? MW'(-prod_i) : MW'(prod_i);

  generate
    if (bcs_pkg::is_pow2(DIVISOR)) begin : g_shift
      localparam int SHIFT = $clog2(DIVISOR);
      assign qmag = mag >> SHIFT;
    end else begin : g_recip
      // shift chosen so rounding error * max magnitude stays below one step
      localparam int SH  = MW + $clog2(DIVISOR);
      localparam int WW  = 2 * MW + 1;
      localparam logic [WW-1:0] RCP = WW'(bcs_pkg::recip_const(DIVISOR, SH));
      logic [WW-1:0] wide;
      assign wide = WW'(mag) * RCP;
      assign qmag = MW'(wide >> SH);
    end
  endgenerate

  assign quo_o = neg ? -$signed({1'b0, qmag}) : $signed({1'b0, qmag});
endmodule

// File: rtl/bcs_clamp.sv
module bcs_clamp #(
  parameter int SW = 18,
  parameter int DW = 8
) (
  input  logic signed [SW-1:0] val_i,
  output logic [DW-1:0]        code_o
);
  localparam logic signed [SW-1:0] LO = SW'(1);
  localparam logic signed [SW-1:0] HI = SW'((1 << DW) - 2);

  // R4: keep the two reserved codes off the output
  always_comb begin
    if (val_i < LO)      code_o = DW'(1);
    else if (val_i > HI) code_o = DW'((1 << DW) - 2);
    else                 code_o = val_i[DW-1:0];
  end
endmodule

// File: rtl/bcs_adjust.sv
module bcs_adjust #(
  parameter int DW         = 8,
  parameter int LUMA_DIV   = 71,
  parameter int CHROMA_DIV = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_bright,
  input  logic [DW-1:0] cfg_contrast,
  input  logic [DW-1:0] cfg_sat,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_luma,
  input  logic [DW-1:0] s_sample,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_luma,
  output logic [DW-1:0] m_sample
);
  localparam int MW  = 2 * DW;
  localparam int PW  = MW + 1;
  localparam int SW  = PW + 1;
  localparam int CTR = 1 << (DW - 1);
  localparam logic [DW:0] CTR_U = (DW + 1)'(CTR);

  logic          adv, accept, idle;
  logic [DW-1:0] act_bright, act_contrast, act_sat;

  logic                 v1, t1;
  logic signed [DW:0]   d1;
  logic [DW-1:0]        g1;
  logic                 v2, t2;
  logic signed [PW-1:0] p2;
  logic signed [PW-1:0] ga, da;
  logic signed [PW-1:0] qy, qc, qsel;
  logic signed [SW-1:0] off, sum;
  logic [DW-1:0]        code;

  // whole pipe moves as one when the output slot frees up (R7)
  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;
  assign accept  = s_valid && adv;
  assign idle    = !v1 && !v2 && !m_valid && !accept;

  bcs_settings #(
    .DW(DW), .R_BRIGHT(CTR), .R_CONTRAST(LUMA_DIV), .R_SAT(CHROMA_DIV)
  ) i_settings (
    .clk(clk), .rst_n(rst_n), .load_i(idle),
    .bright_i(cfg_bright), .contrast_i(cfg_contrast), .sat_i(cfg_sat),
    .bright_o(act_bright), .contrast_o(act_contrast), .sat_o(act_sat)
  );

  // stage 1: remove mid-level offset, pick the gain for this component
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; t1 <= 1'b0; d1 <= '0; g1 <= '0;
    end else if (adv) begin
      v1 <= s_valid;
      t1 <= s_luma;
      d1 <= $signed({1'b0, s_sample} - CTR_U);
      g1 <= s_luma ? act_contrast : act_sat;
    end
  end

  // stage 2: signed product
  assign ga = PW'($signed({1'b0, g1}));
  assign da = PW'(d1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; t2 <= 1'b0; p2 <= '0;
    end else if (adv) begin
      v2 <= v1;
      t2 <= t1;
      p2 <= ga * da;
    end
  end

  // stage 3: normalise, add offset, clamp
  bcs_scale #(.MW(MW), .DIVISOR(LUMA_DIV))   i_scale_y (.prod_i(p2), .quo_o(qy));
  bcs_scale #(.MW(MW), .DIVISOR(CHROMA_DIV)) i_scale_c (.prod_i(p2), .quo_o(qc));

  assign qsel = t2 ? qy : qc;
  assign off  = t2 ? SW'({1'b0, act_bright}) : SW'(CTR);
  assign sum  = SW'(qsel) + off;

  bcs_clamp #(.SW(SW), .DW(DW)) i_clamp (.val_i(sum), .code_o(code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_luma <= 1'b0; m_sample <= '0;
    end else if (adv) begin
      m_valid  <= v2;
      m_luma   <= t2;
      m_sample <= code;
    end
  end
endmodule

// File: rtl/bcs_adjust_chk.sv
module bcs_adjust_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_luma,
  input logic [DW-1:0] m_sample,
  input logic          stage_busy,
  input logic [DW-1:0] act_bright,
  input logic [DW-1:0] act_contrast,
  input logic [DW-1:0] act_sat
);
  localparam logic [DW-1:0] MAXC = DW'((1 << DW) - 2);

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_sample >= DW'(1) && m_sample <= MAXC)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_sample) && $stable(m_luma))); // R7

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R7

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_valid && s_ready, 3) && $past(s_ready, 2) && $past(s_ready, 1)) |-> m_valid); // R6

  AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_busy || m_valid || (s_valid && s_ready)) |=>
      ($stable(act_bright) && $stable(act_contrast) && $stable(act_sat))); // R8
endmodule

bind bcs_adjust bcs_adjust_chk #(.DW(DW)) i_bcs_adjust_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_luma(m_luma), .m_sample(m_sample),
  .stage_busy(v1 || v2), .act_bright(act_bright), .act_contrast(act_contrast),
  .act_sat(act_sat)
);

// File: tb/test_bcs_adjust.sv
`timescale 1ns/1ps
module test_bcs_adjust;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_bright = 8'd128, cfg_contrast = 8'd71, cfg_sat = 8'd64;
  logic       s_valid = 1'b0, s_luma = 1'b0;
  logic [7:0] s_sample = 8'd0;
  logic       s_ready, m_valid, m_luma;
  logic       m_ready = 1'b1;
  logic [7:0] m_sample;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [12:0] expq[$];   // {req[3:0], luma, data}

  always #2 clk = ~clk;   // 250 MHz

  bcs_adjust i_bcs_adjust (
    .clk(clk), .rst_n(rst_n), .cfg_bright(cfg_bright), .cfg_contrast(cfg_contrast),
    .cfg_sat(cfg_sat), .s_valid(s_valid), .s_ready(s_ready), .s_luma(s_luma),
    .s_sample(s_sample), .m_valid(m_valid), .m_ready(m_ready), .m_luma(m_luma),
    .m_sample(m_sample)
  );

  // {req, bright, contrast, sat, luma, in, expected}
  localparam logic [44:0] VEC [16] = '{
    {4'd5, 8'd128, 8'd71,  8'd64,  1'b1, 8'd16,  8'd16 },  // R5 black
    {4'd5, 8'd128, 8'd71,  8'd64,  1'b1, 8'd235, 8'd235},  // R5 white
    {4'd4, 8'd128, 8'd71,  8'd64,  1'b1, 8'd0,   8'd1  },  // R4 low
    {4'd4, 8'd128, 8'd71,  8'd64,  1'b1, 8'd255, 8'd254},  // R4 high
    {4'd5, 8'd128, 8'd71,  8'd64,  1'b0, 8'd240, 8'd240},  // R5 chroma
    {4'd4, 8'd128, 8'd71,  8'd64,  1'b0, 8'd0,   8'd1  },  // R4 chroma low
    {4'd3, 8'd50,  8'd1,   8'd64,  1'b1, 8'd127, 8'd50 },  // R3 -1/71 -> 0
    {4'd3, 8'd50,  8'd1,   8'd64,  1'b1, 8'd0,   8'd49 },  // R3 -128/71 -> -1
    {4'd1, 8'd0,   8'd142, 8'd64,  1'b1, 8'd200, 8'd144},  // R1 exact multiple
    {4'd1, 8'd200, 8'd100, 8'd64,  1'b1, 8'd60,  8'd105},  // R1 -6800/71
    {4'd1, 8'd0,   8'd255, 8'd64,  1'b1, 8'd129, 8'd3  },  // R1 255/71
    {4'd2, 8'd128, 8'd71,  8'd32,  1'b0, 8'd100, 8'd114},  // R2 half gain
    {4'd3, 8'd128, 8'd71,  8'd33,  1'b0, 8'd100, 8'd114},  // R3 -924/64
    {4'd4, 8'd128, 8'd71,  8'd200, 1'b0, 8'd250, 8'd254},  // R4 chroma high
    {4'd2, 8'd128, 8'd71,  8'd0,   1'b0, 8'd17,  8'd128},  // R2 zero gain
    {4'd1, 8'd3,   8'd0,   8'd64,  1'b1, 8'd77,  8'd3  }   // R1 zero gain
  };

  function automatic logic [7:0] ref_out(int b, int c, int s, bit lu, int x);
    int d = x - 128;
    int v = lu ? (c * d) / 71 + b : (s * d) / 64 + 128;
    if (v < 1) v = 1;
    if (v > 254) v = 254;
    return 8'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic lu, logic [7:0] x, logic [7:0] e, int req);
    s_valid = 1'b1; s_luma = lu; s_sample = x;
    while (!s_ready) @(negedge clk);
    expq.push_back({4'(req), lu, e});
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic apply(logic [7:0] b, logic [7:0] c, logic [7:0] s);
    cfg_bright = b; cfg_contrast = c; cfg_sat = s;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // back-pressure source, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // output scoreboard and stall checks
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic       prev_lu;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(m_valid && m_sample == prev_data && m_luma == prev_lu, "R7 hold",
              int'(m_sample), int'(prev_data));
      if (m_valid && !m_ready)
        check(!s_ready, "R7 ready", int'(s_ready), 0);
      if (m_valid && m_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 extra output", int'(m_sample), -1);
        end else begin
          logic [12:0] it;
          it = expq.pop_front();
          check(m_sample == it[7:0], $sformatf("R%0d", it[12:9]),
                int'(m_sample), int'(it[7:0]));
          check(m_luma == it[8], "R9 tag", int'(m_luma), int'(it[8]));
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_data  = m_sample;
      prev_lu    = m_luma;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", expq.size());
      finish_run();
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!m_valid, "R10 m_valid", int'(m_valid), 0);
    check(s_ready, "R10 s_ready", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    foreach (VEC[i]) begin
      logic [44:0] v;
      v = VEC[i];
      apply(v[40:33], v[32:25], v[24:17]);
      push(v[16], v[15:8], v[7:0], int'(v[44:41]));
    end

    // R6 latency with m_ready high
    apply(8'd128, 8'd71, 8'd64);
    push(1'b1, 8'd90, 8'd90, 6);
    check(!m_valid, "R6 after edge 1", int'(m_valid), 0);
    @(negedge clk);
    check(!m_valid, "R6 after edge 2", int'(m_valid), 0);
    @(negedge clk);
    check(m_valid && m_sample == 8'd90, "R6 after edge 3", int'(m_sample), 90);

    // R8 settings change while samples are in flight
    apply(8'd128, 8'd71, 8'd64);
    push(1'b1, 8'd100, 8'd100, 8);
    cfg_bright = 8'd0; cfg_contrast = 8'd0;
    push(1'b1, 8'd50, 8'd50, 8);
    push(1'b0, 8'd200, 8'd200, 8);
    apply(8'd0, 8'd0, 8'd64);
    push(1'b1, 8'd100, 8'd1, 8);

    // R7 random back-pressure, mixed tags
    apply(8'd20, 8'd90, 8'd100);
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      bit lu = i[0];
      int x  = (i * 37 + 5) % 256;
      push(lu, 8'(x), ref_out(20, 90, 100, lu, x), 7);
    end
    while (expq.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (3) @(negedge clk);

    // R1 full sweep of contrast gain against luma
    for (int c = 0; c < 256; c++) begin
      int b = (c * 7) % 256;
      apply(8'(b), 8'(c), 8'd64);
      for (int y = 0; y < 256; y++) push(1'b1, 8'(y), ref_out(b, c, 64, 1'b1, y), 1);
    end

    // R2 full sweep of saturation gain against chroma
    for (int s = 0; s < 256; s++) begin
      apply(8'd128, 8'd71, 8'(s));
      for (int x = 0; x < 256; x++) push(1'b0, 8'(x), ref_out(128, 71, s, 1'b0, x), 2);
    end

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule